// File: doc/BRIEF.md
# Configuration Unlock Window

This block keeps three configuration registers (clock source select, clock divider and watchdog control) safe from stray writes. Software opens a short write window by storing a fixed 8-bit key at the unlock address on the CPU's I/O write bus. The window then stays open for a set number of completed instructions, which are counted by the CPU's instruction-done strobe. The three guarded registers accept writes only while the window is open.

While the window is open, the block raises an interrupt-block output, so the CPU accepts no interrupts during the unlock sequence. When the window closes, the output drops and normal interrupt handling resumes without any action from software. Reading the unlock address returns the window state in bit 0, and every other bit of that read is zero.

The I/O write bus drives the block directly. Readback is combinational on the address bus.

Top module: `cfg_unlock`

## Requirements
- R1: After reset the window is closed, `irq_block` is 0, and all three guarded registers and the unlock readback are 0x00.
- R2: A write of KEY (default 0xD8) to LOCK_ADDR opens the window. `irq_block` reads 1 from the next clock edge.
- R3: An open window stays open for exactly WINDOW (default 4) cycles in which `instr_done` is high. It closes on the edge that samples the WINDOW-th strobe. Cycles without a strobe do not count.
- R4: A write to SRC_ADDR, DIV_ADDR or WDOG_ADDR while the window is open updates that register on the next edge. Such a write does not shorten the window.
- R5: A write to a guarded register while the window is closed is discarded, and the register keeps its value.
- R6: `irq_block` is 1 exactly while the window is open. It can only rise after a key write.
- R7: Reading LOCK_ADDR returns the window state in bit 0. Bits 7:1 are always 0.
- R8: A write of any value other than KEY to LOCK_ADDR does not open the window, and it closes a window that is already open.
- R9: A key write while the window is open restarts the count at WINDOW. This holds even when `instr_done` is high in the same cycle.
- R10: Reading a guarded register's address returns its contents. Reading any other unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_we | input | 1 | I/O write strobe |
| io_addr | input | ADDR_W | I/O address for both writes and reads |
| io_wdata | input | 8 | I/O write data |
| instr_done | input | 1 | Instruction-completion strobe |
| io_rdata | output | 8 | Combinational readback for `io_addr` |
| irq_block | output | 1 | High while interrupts must be ignored |
| clk_src_q | output | 8 | Clock source select register |
| clk_div_q | output | 8 | Clock divider register |
| wdog_q | output | 8 | Watchdog control register |

## Verification
The bench builds the block with its default parameters: a 6-bit address space, the key 0xD8 and a window of four strobes. With a window that short, every boundary can be reached in a few cycles. These include the close on the fourth strobe, a reload that collides with a strobe, and a guarded write landing on the last open cycle. With the default key, the bench can also check that a single wrong value shuts a window already in progress.

// File: rtl/cfg_unlock.sv
module cfg_unlock #(
  parameter int ADDR_W = 6,
  parameter logic [7:0] KEY = 8'hD8,
  parameter int WINDOW = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 6'h3C,
  parameter logic [ADDR_W-1:0] SRC_ADDR  = 6'h39,
  parameter logic [ADDR_W-1:0] DIV_ADDR  = 6'h36,
  parameter logic [ADDR_W-1:0] WDOG_ADDR = 6'h31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              instr_done,
  output logic [7:0]        io_rdata,
  output logic              irq_block,
  output logic [7:0]        clk_src_q,
  output logic [7:0]        clk_div_q,
  output logic [7:0]        wdog_q
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  logic [CNT_W-1:0] left;
  logic open_w, lock_wr, key_wr, bad_wr, wr_ok;

  assign open_w  = (left != '0);
  assign lock_wr = io_we && (io_addr == LOCK_ADDR);
  assign key_wr  = lock_wr && (io_wdata == KEY);
  assign bad_wr  = lock_wr && (io_wdata != KEY);
  assign wr_ok   = io_we && open_w;
  assign irq_block = open_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   left <= '0;
    else if (key_wr)              left <= CNT_W'(WINDOW);
    else if (bad_wr)              left <= '0;
    else if (instr_done && open_w) left <= left - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_src_q <= '0;
      clk_div_q <= '0;
      wdog_q    <= '0;
    end else if (wr_ok) begin
      if (io_addr == SRC_ADDR)  clk_src_q <= io_wdata;
      if (io_addr == DIV_ADDR)  clk_div_q <= io_wdata;
      if (io_addr == WDOG_ADDR) wdog_q    <= io_wdata;
    end
  end

  always_comb begin
    io_rdata = 8'h00;
    if (io_addr == LOCK_ADDR)      io_rdata = {7'b0, open_w};
    else if (io_addr == SRC_ADDR)  io_rdata = clk_src_q;
    else if (io_addr == DIV_ADDR)  io_rdata = clk_div_q;
    else if (io_addr == WDOG_ADDR) io_rdata = wdog_q;
  end
endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk #(
  parameter int ADDR_W = 6,
  parameter logic [7:0] KEY = 8'hD8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 6'h3C,
  parameter logic [ADDR_W-1:0] SRC_ADDR  = 6'h39,
  parameter logic [ADDR_W-1:0] DIV_ADDR  = 6'h36,
  parameter logic [ADDR_W-1:0] WDOG_ADDR = 6'h31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_we,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              instr_done,
  input logic [7:0]        io_rdata,
  input logic              irq_block,
  input logic [7:0]        clk_src_q,
  input logic [7:0]        clk_div_q,
  input logic [7:0]        wdog_q
);
  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == LOCK_ADDR && io_wdata == KEY) |=> irq_block);

  assert_bad_key_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == LOCK_ADDR && io_wdata != KEY) |=> !irq_block);

  assert_hold_without_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_block && !instr_done && !(io_we && io_addr == LOCK_ADDR)) |=> irq_block);

  assert_open_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_block && io_we && io_addr == DIV_ADDR) |=> (clk_div_q == $past(io_wdata)));

  assert_locked_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_block && io_we && io_addr == SRC_ADDR) |=> $stable(clk_src_q));

  assert_locked_wdog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_block && io_we && io_addr == WDOG_ADDR) |=> $stable(wdog_q));

  assert_rise_needs_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_block) |-> $past(io_we && io_addr == LOCK_ADDR && io_wdata == KEY));

  assert_lock_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == LOCK_ADDR) |-> (io_rdata[7:1] == 7'b0));
endmodule

bind cfg_unlock cfg_unlock_chk #(
  .ADDR_W(ADDR_W), .KEY(KEY), .LOCK_ADDR(LOCK_ADDR),
  .SRC_ADDR(SRC_ADDR), .DIV_ADDR(DIV_ADDR), .WDOG_ADDR(WDOG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_addr(io_addr),
  .io_wdata(io_wdata), .instr_done(instr_done), .io_rdata(io_rdata),
  .irq_block(irq_block), .clk_src_q(clk_src_q), .clk_div_q(clk_div_q),
  .wdog_q(wdog_q)
);

// File: tb/cfg_unlock_bench.sv
module cfg_unlock_bench;
  localparam logic [5:0] LK = 6'h3C, SR = 6'h39, DV = 6'h36, WD = 6'h31;
  localparam int NV = 16;
  // {we, addr[5:0], wdata[7:0], done, expected irq_block}
  localparam logic [16:0] VEC [0:NV-1] = '{
    {1'b1, LK, 8'hD8, 1'b0, 1'b1},  // R2 open
    {1'b0, LK, 8'h00, 1'b0, 1'b1},  // R3 no strobe, no count
    {1'b0, LK, 8'h00, 1'b1, 1'b1},
    {1'b0, LK, 8'h00, 1'b1, 1'b1},
    {1'b0, LK, 8'h00, 1'b1, 1'b1},
    {1'b0, LK, 8'h00, 1'b1, 1'b0},  // R3 fourth strobe closes
    {1'b0, LK, 8'h00, 1'b1, 1'b0},
    {1'b1, LK, 8'hD8, 1'b0, 1'b1},
    {1'b1, LK, 8'hD9, 1'b0, 1'b0},  // R8 wrong value closes
    {1'b1, LK, 8'h58, 1'b0, 1'b0},  // R8 wrong value does not open
    {1'b1, LK, 8'hD8, 1'b1, 1'b1},
    {1'b0, LK, 8'h00, 1'b1, 1'b1},
    {1'b1, LK, 8'hD8, 1'b1, 1'b1},  // R9 reload wins over strobe
    {1'b0, LK, 8'h00, 1'b1, 1'b1},
    {1'b0, LK, 8'h00, 1'b1, 1'b1},
    {1'b0, LK, 8'h00, 1'b1, 1'b1}
  };

  logic clk = 0, rst_n = 0, io_we = 0, instr_done = 0;
  logic [5:0] io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata, clk_src_q, clk_div_q, wdog_q;
  logic irq_block;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  cfg_unlock u_cfg_unlock (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .instr_done(instr_done), .io_rdata(io_rdata),
    .irq_block(irq_block), .clk_src_q(clk_src_q), .clk_div_q(clk_div_q),
    .wdog_q(wdog_q)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [5:0] a, input logic [7:0] d, input logic dn);
    io_we = we; io_addr = a; io_wdata = d; instr_done = dn;
    @(posedge clk); #2;
    io_we = 0; instr_done = 0;
  endtask

  task automatic rd(input string req, input logic [5:0] a, input logic [7:0] exp);
    io_addr = a; #1;
    check(req, io_rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    @(posedge clk); #2;
    check("R1 irq_block", {7'b0, irq_block}, 8'h00);
    rd("R1 lock", LK, 8'h00);
    rd("R1 src", SR, 8'h00);
    rd("R1 div", DV, 8'h00);
    rd("R1 wdog", WD, 8'h00);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][16], VEC[i][15:10], VEC[i][9:2], VEC[i][1]);
      check($sformatf("R3/R6 vec%0d irq_block", i), {7'b0, irq_block}, {7'b0, VEC[i][0]});
      rd($sformatf("R7 vec%0d lock read", i), LK, {7'b0, VEC[i][0]});
    end
    cyc(0, LK, 8'h00, 1);
    check("R3 after reload close", {7'b0, irq_block}, 8'h00);

    // R5: locked writes are discarded
    cyc(1, SR, 8'h5A, 1);
    cyc(1, WD, 8'h3C, 0);
    rd("R5 src locked", SR, 8'h00);
    rd("R5 wdog locked", WD, 8'h00);

    // R4: open writes land and do not shorten the window
    cyc(1, LK, 8'hD8, 0);
    cyc(1, SR, 8'h05, 1);
    cyc(1, DV, 8'h03, 1);
    cyc(0, LK, 8'h00, 1);
    check("R4 window still open", {7'b0, irq_block}, 8'h01);
    cyc(1, WD, 8'h29, 1);  // last open cycle
    check("R4 window closes on 4th strobe", {7'b0, irq_block}, 8'h00);
    rd("R4 src", SR, 8'h05);
    rd("R4 div", DV, 8'h03);
    rd("R4 wdog last cycle", WD, 8'h29);
    cyc(1, DV, 8'hFF, 0);
    rd("R5 div after close", DV, 8'h03);
    rd("R10 unmapped", 6'h00, 8'h00);
    rd("R10 unmapped hi", 6'h3F, 8'h00);
    rd("R7 lock closed", LK, 8'h00);

    // R1: reset clears everything
    rst_n = 0; #3; rst_n = 1;
    rd("R1 src after reset", SR, 8'h00);
    rd("R1 wdog after reset", WD, 8'h00);
    check("R1 irq_block after reset", {7'b0, irq_block}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule